// File: doc/BRIEF.md
# Circuit-Switched Mesh Router Node

This block is one node of a two-dimensional mesh that moves data over reserved circuits. It has five ports: north, east, south, west and local. Each port carries a request, a destination address and a data word in each direction, plus a grant that runs against the data flow. A source raises its request together with a destination address. The node works out which output leads toward that destination and settles any contention for that output. It then locks a crossbar path from the winning input to that output. The request and address go on to the next node over the locked path, and the grant that comes back from the next node is passed back to the requester.

Data moves only after the whole path is reserved. While the source holds its request, the data word streams through the crossbar. When the source drops its request, the node frees the path at the next clock edge, and the drop travels on one node per cycle. The node has no queues. A request that cannot get its output stays raised and waits.

Top module: `mesh_cs_router`

## Requirements
- R1: While reset is held (active-low, asynchronous), and after it is released with every request low, all req_out, addr_out, data_out and grant_out bits are 0.
- R2: The output is chosen by XY order. The port index encoding is 0 north, 1 east, 2 south, 3 west, 4 local. The address is {x[1:0], y[1:0]}, with x in bits 3:2 and y in bits 1:0. The node sits at (MY_X, MY_Y), where east is larger x and north is larger y. The rules are applied in this order: x above MY_X goes east, x below MY_X goes west, y above MY_Y goes north, y below MY_Y goes south, and otherwise the output is local. A locked output's addr_out equals the winning input's addr_in.
- R3: Suppose an input requests a free output and wins at a clock edge. From that edge on, req_out for that output is 1. It stays 1, tied to that same input, for as long as the input holds its request.
- R4: grant_out of an input equals grant_in of the output that input holds, in the same cycle. It is 0 for an input that holds no output.
- R5: data_out of a held output equals data_in of its input in the same cycle. data_out and addr_out of a free output are 0.
- R6: If an input's request is low at a clock edge while it holds an output, that output is free after that edge (req_out 0). Another input can win the output at the following edge at the earliest.
- R7: Each output arbitrates round-robin over input indices. The search starts at the index after the last winner of that output and starts at 0 after reset.
- R8: A request that loses stays pending and receives grant_out 0 until the output is free and the request wins.
- R9: Circuits to different outputs are set up and run at the same time without interfering. An input holds at most one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 5 | Request from each input port |
| addr_in | input | 5x4 | Destination {x,y} with each input request |
| data_in | input | 5x8 | Data word from each input port |
| grant_out | output | 5 | Grant relayed back to each input port |
| req_out | output | 5 | Request forwarded on each output port |
| addr_out | output | 5x4 | Destination forwarded on each output port |
| data_out | output | 5x8 | Data word driven on each output port |
| grant_in | input | 5 | Grant returned by the next node on each output |

## Verification
The bench targets the cycle of release. A design that frees the path one edge late keeps req_out high for an extra cycle. A design that frees it early, or reassigns the output in the same edge, shows the waiting input taking over too soon.

It also tests two inputs contending for the local output. A round-robin pointer that never advances, or restarts wrongly, hands the output to the same input twice. A node that returns a grant to the losing input would let that input send data with no path.

Directed requests sweep each of the five routing outcomes, so a swapped compare sends req_out to the wrong side. Long random traffic then checks that concurrent circuits never cross data or grants.

// File: rtl/mesh_cs_pkg.sv
package mesh_cs_pkg;
    localparam int NPORT = 5;
    localparam int PIDW  = 3;

    typedef logic [PIDW-1:0] pidx_t;

    typedef enum int {
        P_NORTH = 0,
        P_EAST  = 1,
        P_SOUTH = 2,
        P_WEST  = 3,
        P_LOCAL = 4
    } port_e;

    typedef struct packed {
        logic [NPORT-1:0]  held;
        pidx_t [NPORT-1:0] conn;
        pidx_t [NPORT-1:0] ptr;
    } ctl_t;
endpackage

// File: rtl/cs_xy_route.sv
module cs_xy_route
    import mesh_cs_pkg::*;
#(
    parameter int XW   = 2,
    parameter int YW   = 2,
    parameter int MY_X = 1,
    parameter int MY_Y = 2
) (
    input  logic [XW+YW-1:0] dest,
    output logic [NPORT-1:0] dir
);
    logic [XW-1:0] dx;
    logic [YW-1:0] dy;

    assign dx = dest[XW+YW-1:YW];
    assign dy = dest[YW-1:0];

    always_comb begin
        dir = '0;
        if (dx > XW'(MY_X))      dir[P_EAST]  = 1'b1;
        else if (dx < XW'(MY_X)) dir[P_WEST]  = 1'b1;
        else if (dy > YW'(MY_Y)) dir[P_NORTH] = 1'b1;
        else if (dy < YW'(MY_Y)) dir[P_SOUTH] = 1'b1;
        else                     dir[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/cs_rr_arbiter.sv
module cs_rr_arbiter
    import mesh_cs_pkg::*;
(
    input  logic [NPORT-1:0] req,
    input  pidx_t            ptr,
    output logic             valid,
    output pidx_t            idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = 0; k < NPORT; k++) begin
            int c;
            c = (int'(ptr) + k) % NPORT;
            if (!valid && req[c]) begin
                valid = 1'b1;
                idx   = pidx_t'(c);
            end
        end
    end
endmodule

// File: rtl/cs_crossbar.sv
module cs_crossbar
    import mesh_cs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NPORT-1:0]        held,
    input  pidx_t [NPORT-1:0]       conn,
    input  logic [NPORT-1:0][W-1:0] din,
    output logic [NPORT-1:0][W-1:0] dout
);
    for (genvar o = 0; o < NPORT; o++) begin : g_out
        assign dout[o] = held[o] ? din[conn[o]] : '0;
    end
endmodule

// File: rtl/mesh_cs_router.sv
module mesh_cs_router
    import mesh_cs_pkg::*;
#(
    parameter int XW   = 2,
    parameter int YW   = 2,
    parameter int DW   = 8,
    parameter int MY_X = 1,
    parameter int MY_Y = 2,
    localparam int AW  = XW + YW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT-1:0]         req_in,
    input  logic [NPORT-1:0][AW-1:0] addr_in,
    input  logic [NPORT-1:0][DW-1:0] data_in,
    output logic [NPORT-1:0]         grant_out,
    output logic [NPORT-1:0]         req_out,
    output logic [NPORT-1:0][AW-1:0] addr_out,
    output logic [NPORT-1:0][DW-1:0] data_out,
    input  logic [NPORT-1:0]         grant_in
);
    ctl_t st_d, st_q;

    logic [NPORT-1:0][NPORT-1:0] dir;
    logic [NPORT-1:0][NPORT-1:0] cand;
    logic [NPORT-1:0]            busy;
    logic [NPORT-1:0]            win_v;
    pidx_t [NPORT-1:0]           win_i;
    logic [NPORT-1:0]            held_q;
    pidx_t [NPORT-1:0]           conn_q;

    assign held_q = st_q.held;
    assign conn_q = st_q.conn;

    for (genvar i = 0; i < NPORT; i++) begin : g_route
        cs_xy_route #(.XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .dest (addr_in[i]),
            .dir  (dir[i])
        );
    end

    always_comb begin
        busy      = '0;
        grant_out = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (st_q.held[o] && st_q.conn[o] == pidx_t'(i)) begin
                    busy[i]      = 1'b1;
                    grant_out[i] = grant_in[o];
                end
            end
        end
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                cand[o][i] = req_in[i] & dir[i][o] & ~busy[i];
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_arb
        cs_rr_arbiter u_arb (
            .req   (cand[o]),
            .ptr   (st_q.ptr[o]),
            .valid (win_v[o]),
            .idx   (win_i[o])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int o = 0; o < NPORT; o++) begin
            if (st_q.held[o]) begin
                if (!req_in[st_q.conn[o]]) st_d.held[o] = 1'b0;
            end else if (win_v[o]) begin
                st_d.held[o] = 1'b1;
                st_d.conn[o] = win_i[o];
                st_d.ptr[o]  = (win_i[o] == pidx_t'(NPORT-1)) ? '0 : win_i[o] + pidx_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_out = st_q.held;

    cs_crossbar #(.W(AW)) u_xbar_addr (
        .held (st_q.held),
        .conn (st_q.conn),
        .din  (addr_in),
        .dout (addr_out)
    );

    cs_crossbar #(.W(DW)) u_xbar_data (
        .held (st_q.held),
        .conn (st_q.conn),
        .din  (data_in),
        .dout (data_out)
    );
endmodule

// File: rtl/mesh_cs_router_chk.sv
module mesh_cs_router_chk
    import mesh_cs_pkg::*;
#(
    parameter int DW = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NPORT-1:0]         req_in,
    input logic [NPORT-1:0]         grant_in,
    input logic [NPORT-1:0]         grant_out,
    input logic [NPORT-1:0]         req_out,
    input logic [NPORT-1:0][DW-1:0] data_out,
    input logic [NPORT-1:0]         held_q,
    input pidx_t [NPORT-1:0]        conn_q
);
    logic [NPORT-1:0][NPORT-1:0] owns;

    always_comb begin
        for (int i = 0; i < NPORT; i++)
            for (int o = 0; o < NPORT; o++)
                owns[i][o] = held_q[o] && conn_q[o] == pidx_t'(i);
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_o
        AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            (held_q[o] && req_in[conn_q[o]]) |=> (req_out[o] && $stable(conn_q[o]))); // R3
        AST_FREE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (held_q[o] && !req_in[conn_q[o]]) |=> !req_out[o]); // R6
        AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !req_out[o] |-> data_out[o] == '0); // R5
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_i
        AST_GRANT_NEEDS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
            grant_out[i] |-> (|(grant_in & req_out))); // R4
        AST_ONE_PATH_PER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(owns[i]) <= 1); // R9
    end
endmodule

bind mesh_cs_router mesh_cs_router_chk #(.DW(DW)) u_chk (.*);

// File: tb/mesh_cs_router_test.sv
module mesh_cs_router_test;
    localparam int NP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]       req_in = '0;
    logic [NP-1:0][3:0]  addr_in = '0;
    logic [NP-1:0][7:0]  data_in = '0;
    logic [NP-1:0]       grant_in = '0;
    logic [NP-1:0]       grant_out, req_out;
    logic [NP-1:0][3:0]  addr_out;
    logic [NP-1:0][7:0]  data_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_held [NP];
    int m_conn [NP];
    int m_ptr  [NP];
    int s_hold [NP];

    always #2 clk = ~clk;

    mesh_cs_router uut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .addr_in(addr_in), .data_in(data_in),
        .grant_out(grant_out), .req_out(req_out), .addr_out(addr_out),
        .data_out(data_out), .grant_in(grant_in)
    );

    function automatic int route(logic [3:0] a);
        int x = int'(a[3:2]);
        int y = int'(a[1:0]);
        if (x > 1) return 1;
        if (x < 1) return 3;
        if (y > 2) return 0;
        if (y < 2) return 2;
        return 4;
    endfunction

    function automatic bit owns_any(int i);
        for (int o = 0; o < NP; o++)
            if (m_held[o] != 0 && m_conn[o] == i) return 1;
        return 0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int o = 0; o < NP; o++) begin
            m_held[o] = 0; m_conn[o] = 0; m_ptr[o] = 0; s_hold[o] = 0;
        end
    endtask

    task automatic model_update();
        int n_held [NP];
        int n_conn [NP];
        int n_ptr  [NP];
        bit busy [NP];
        for (int i = 0; i < NP; i++) busy[i] = owns_any(i);
        for (int o = 0; o < NP; o++) begin
            n_held[o] = m_held[o]; n_conn[o] = m_conn[o]; n_ptr[o] = m_ptr[o];
            if (m_held[o] != 0) begin
                if (!req_in[m_conn[o]]) n_held[o] = 0;
            end else begin
                for (int k = 0; k < NP; k++) begin
                    int c = (m_ptr[o] + k) % NP;
                    if (n_held[o] == 0 && req_in[c] && !busy[c] && route(addr_in[c]) == o) begin
                        n_held[o] = 1; n_conn[o] = c; n_ptr[o] = (c + 1) % NP;
                    end
                end
            end
        end
        for (int o = 0; o < NP; o++) begin
            m_held[o] = n_held[o]; m_conn[o] = n_conn[o]; m_ptr[o] = n_ptr[o];
        end
    endtask

    task automatic compare();
        logic [NP-1:0] e_req, e_gnt;
        logic [NP-1:0][3:0] e_addr;
        logic [NP-1:0][7:0] e_data;
        e_req = '0; e_gnt = '0; e_addr = '0; e_data = '0;
        for (int o = 0; o < NP; o++) begin
            if (m_held[o] != 0) begin
                e_req[o] = 1'b1;
                e_addr[o] = addr_in[m_conn[o]];
                e_data[o] = data_in[m_conn[o]];
                e_gnt[m_conn[o]] = grant_in[o];
            end
        end
        chk("R3 req_out", 64'(req_out), 64'(e_req));
        chk("R2 addr_out", 64'(addr_out), 64'(e_addr));
        chk("R5 data_out", 64'(data_out), 64'(e_data));
        chk("R4 grant_out", 64'(grant_out), 64'(e_gnt));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        compare();
    endtask

    task automatic single_route(int src, logic [3:0] a, int exp_port);
        req_in[src] = 1'b1; addr_in[src] = a; data_in[src] = 8'(8'h30 + exp_port);
        grant_in = '1;
        step();
        chk("R2 route port", 64'(req_out), 64'(1 << exp_port));
        chk("R4 grant back", 64'(grant_out[src]), 64'd1);
        req_in[src] = 1'b0;
        step();
        chk("R6 release next edge", 64'(req_out), 64'd0);
        grant_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        model_reset();
        #1;
        chk("R1 reset req_out", 64'(req_out), 64'd0);
        chk("R1 reset grant_out", 64'(grant_out), 64'd0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        chk("R1 after reset data_out", 64'(data_out), 64'd0);
        chk("R1 after reset addr_out", 64'(addr_out), 64'd0);

        // R2 routing sweep from node (1,2)
        single_route(4, 4'b11_00, 1);
        single_route(4, 4'b00_11, 3);
        single_route(4, 4'b01_11, 0);
        single_route(4, 4'b01_00, 2);
        single_route(0, 4'b01_10, 4);

        // R7 / R8 contention for local output; its pointer is now 1
        req_in[0] = 1'b1; addr_in[0] = 4'b01_10; data_in[0] = 8'hA0;
        req_in[2] = 1'b1; addr_in[2] = 4'b01_10; data_in[2] = 8'hA2;
        grant_in = 5'b10000;
        step();
        chk("R7 rr winner input 2", 64'(data_out[4]), 64'h0A2);
        chk("R8 loser no grant", 64'(grant_out), 64'b00100);
        step();
        step();
        chk("R8 loser still waits", 64'(grant_out[0]), 64'd0);
        req_in[2] = 1'b0;
        step();
        chk("R6 freed, not reassigned same edge", 64'(req_out[4]), 64'd0);
        step();
        chk("R8 waiting input wins", 64'(grant_out), 64'b00001);
        chk("R7 second winner data", 64'(data_out[4]), 64'h0A0);
        req_in = '0;
        step();

        // R9 concurrent circuits
        req_in[4] = 1'b1; addr_in[4] = 4'b10_10; data_in[4] = 8'h44;
        req_in[1] = 1'b1; addr_in[1] = 4'b00_10; data_in[1] = 8'h11;
        grant_in = 5'b01010;
        step();
        chk("R9 two outputs held", 64'(req_out), 64'b01010);
        chk("R9 east data", 64'(data_out[1]), 64'h44);
        chk("R9 west data", 64'(data_out[3]), 64'h11);
        chk("R9 both grants", 64'(grant_out), 64'b10010);
        req_in = '0; grant_in = '0;
        step();

        // random traffic against the bench model
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NP; i++) begin
                if (req_in[i]) begin
                    if (owns_any(i)) begin
                        if (s_hold[i] == 0) req_in[i] = 1'b0;
                        else s_hold[i]--;
                    end
                end else if ($urandom % 4 == 0) begin
                    req_in[i] = 1'b1;
                    addr_in[i] = 4'($urandom);
                    s_hold[i] = int'($urandom % 6);
                end
                data_in[i] = 8'($urandom);
            end
            grant_in = 5'($urandom);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule